// File: doc/BRIEF.md
# Parallel Multi-Lane LED Waveform Encoder

The encoder drives several single-wire, self-clocked addressable-LED data lines in lockstep, one output per lane. A single three-phase bit timer is shared by every lane. Each bit period opens with all enabled lanes going high together. After the first interval, the lanes whose current bit is zero fall. After the second interval, every lane falls and stays low for the third interval. What a lane's bit decides is only whether that lane drops at the middle boundary, so many strips receive their colour streams at the same moment.

Software-side logic starts a frame with a strobe. The strobe captures a lane-enable mask, the three phase durations in clock cycles and a colour-order code. Pixels then arrive through a valid/ready handshake, one 24-bit pixel per lane per transfer, with a flag that marks the final pixel. The block puts each lane's three colour bytes in the selected order and transmits every byte most-significant bit first.

A one-pixel holding register lets the next pixel be taken during the last bit of the current one, so a continuous stream has no gaps. If data runs dry at a pixel boundary, the lines sit low. If the wait grows longer than the reset interval minus a safety margin, the frame is abandoned. Every frame, whether complete or abandoned, ends with a guaranteed low interval and then a one-cycle done pulse.

Top module: `led_par_enc`

## Requirements
- R1: After reset all lane outputs are low, and busy, ready, done and aborted are all 0.
- R2: A start strobe seen while idle captures lane mask, phase durations and order code for the whole frame; a start strobe while busy is ignored and the captured values stay in force.
- R3: Every bit period lasts t_high+t_data+t_low cycles (each at least 1), and at its first cycle all enabled lanes go high together.
- R4: A 0 bit keeps its lane high for t_high cycles and a 1 bit for t_high+t_data cycles; the lane is low for the rest of the period.
- R5: Each pixel sends 24 bits per lane: three bytes, each most-significant bit first.
- R6: pix_data_i holds R in bits 23:16, G in 15:8 and B in 7:0 of each lane's slice. Order code 0 sends G,R,B, 1 sends R,G,B, 2 sends R,B,G, 3 sends G,B,R, 4 sends B,R,G, 5 sends B,G,R, and 6 or 7 send G,R,B.
- R7: Lanes whose mask bit is 0 never go high.
- R8: While transmitting, ready is raised only during the last bit of a pixel and only when more pixels are due. A pixel accepted by then starts its first bit right after the previous pixel's last bit, with no idle cycles in between.
- R9: After the last bit period of the final pixel, the lines stay low for IDLE_CYC cycles. Done then pulses for one cycle, in the first cycle with busy low.
- R10: If no pixel is available at a pixel boundary, the lines stay low. A pixel accepted within IDLE_CYC-MARGIN_CYC cycles resumes transmission with no loss of data.
- R11: If the boundary wait reaches IDLE_CYC-MARGIN_CYC cycles, aborted pulses once, exactly that many cycles after the end of the last bit period. The normal low interval and done pulse then follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-frame strobe, used only while idle |
| lane_en_i | input | LANES | Lane enable mask captured at start |
| t_high_i | input | TW | Cycles all lanes are high at the start of a bit |
| t_data_i | input | TW | Further cycles a 1 bit stays high |
| t_low_i | input | TW | Closing cycles with every lane low |
| order_i | input | 3 | Colour-order code captured at start |
| pix_valid_i | input | 1 | Pixel transfer valid |
| pix_last_i | input | 1 | Marks the final pixel of the frame |
| pix_data_i | input | 24*LANES | One RGB pixel per lane, lane l at bits 24l+23:24l |
| pix_ready_o | output | 1 | Encoder can take a pixel this cycle |
| lanes_o | output | LANES | LED data lines |
| busy_o | output | 1 | Frame in progress, including the closing low interval |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| aborted_o | output | 1 | One-cycle pulse when a starved frame is abandoned |

## Verification
Some properties are checked by assertions on every cycle. Lines stay low while idle, masked lanes never rise, and any rise from an all-low state raises exactly the enabled set. The captured mask survives a start strobe that arrives mid-frame. Ready appears only while busy, and done and aborted are single pulses on quiet lines. Other behaviours can only be shown by the bench scenarios, because they need a decoded bit stream and counted intervals: that the high widths encode the right bits, the byte order for each colour code, the absence of gaps between consecutive pixels, the resumption after a short starvation, and the exact cycle at which the abort and done pulses appear.

// File: rtl/led_par_pkg.sv
package led_par_pkg;

    localparam int PIX_BITS  = 24;
    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRIME = 3'd1,
        ST_SEND  = 3'd2,
        ST_STALL = 3'd3,
        ST_GAP   = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        PH_HIGH = 2'd0,
        PH_DATA = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Rearranges an {R,G,B} pixel so the first byte to send sits on top.
    function automatic logic [PIX_BITS-1:0] order_pix(input logic [PIX_BITS-1:0] rgb,
                                                      input logic [2:0]          code);
        logic [BYTE_BITS-1:0] r, g, b;
        logic [PIX_BITS-1:0]  w;
        r = rgb[2*BYTE_BITS +: BYTE_BITS];
        g = rgb[BYTE_BITS   +: BYTE_BITS];
        b = rgb[0           +: BYTE_BITS];
        case (code)
            3'd1:    w = {r, g, b};
            3'd2:    w = {r, b, g};
            3'd3:    w = {g, b, r};
            3'd4:    w = {b, r, g};
            3'd5:    w = {b, g, r};
            default: w = {g, r, b};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/led_phase_timer.sv
module led_phase_timer
    import led_par_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [TW-1:0] t_high_i,
    input  logic [TW-1:0] t_data_i,
    input  logic [TW-1:0] t_low_i,
    output phase_e        phase_o,
    output logic          bit_end_o
);

    localparam int CNTW = TW + 2;

    typedef struct packed {
        logic [CNTW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    logic [CNTW-1:0] edge_a;
    logic [CNTW-1:0] edge_b;
    logic [CNTW-1:0] period;

    always_comb begin
        edge_a = CNTW'(t_high_i);
        edge_b = edge_a + CNTW'(t_data_i);
        period = edge_b + CNTW'(t_low_i);

        bit_end_o = run_i && (q.cnt == period - 1'b1);

        if (q.cnt < edge_a) begin
            phase_o = PH_HIGH;
        end else if (q.cnt < edge_b) begin
            phase_o = PH_DATA;
        end else begin
            phase_o = PH_LOW;
        end

        d = q;
        if (!run_i || bit_end_o) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/led_pix_order.sv
module led_pix_order
    import led_par_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [2:0]                code_i,
    input  logic [LANES*PIX_BITS-1:0] rgb_i,
    output logic [LANES*PIX_BITS-1:0] word_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign word_o[l*PIX_BITS +: PIX_BITS] = order_pix(rgb_i[l*PIX_BITS +: PIX_BITS], code_i);
    end

endmodule

// File: rtl/led_lane_drive.sv
module led_lane_drive
    import led_par_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             active_i,
    input  phase_e           phase_i,
    input  logic [LANES-1:0] en_i,
    input  logic [LANES-1:0] bit_i,
    output logic [LANES-1:0] lanes_o
);

    logic raise_all;
    logic pass_bit;

    assign raise_all = active_i && (phase_i == PH_HIGH);
    assign pass_bit  = active_i && (phase_i == PH_DATA);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lanes_o[l] = en_i[l] && (raise_all || (pass_bit && bit_i[l]));
    end

endmodule

// File: rtl/led_par_enc.sv
module led_par_enc
    import led_par_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int TW         = 12,
    parameter int IDLE_CYC   = 400,
    parameter int MARGIN_CYC = 40
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [LANES-1:0]          lane_en_i,
    input  logic [TW-1:0]             t_high_i,
    input  logic [TW-1:0]             t_data_i,
    input  logic [TW-1:0]             t_low_i,
    input  logic [2:0]                order_i,
    input  logic                      pix_valid_i,
    input  logic                      pix_last_i,
    input  logic [LANES*PIX_BITS-1:0] pix_data_i,
    output logic                      pix_ready_o,
    output logic [LANES-1:0]          lanes_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      aborted_o
);

    localparam int PW        = LANES * PIX_BITS;
    localparam int CW        = $clog2(IDLE_CYC + 1);
    localparam int ABORT_LIM = (IDLE_CYC > MARGIN_CYC + 1) ? (IDLE_CYC - MARGIN_CYC) : 1;
    localparam logic [CW-1:0] GAP_LAST   = CW'(IDLE_CYC - 1);
    localparam logic [CW-1:0] ABORT_LAST = CW'(ABORT_LIM - 1);
    localparam logic [4:0]    LAST_BIT   = 5'(PIX_BITS - 1);

    typedef struct packed {
        state_e           st;
        logic [LANES-1:0] en;
        logic [TW-1:0]    th;
        logic [TW-1:0]    td;
        logic [TW-1:0]    tl;
        logic [2:0]       ord;
        logic [PW-1:0]    cur;
        logic [4:0]       bitn;
        logic             last;
        logic [PW-1:0]    hold;
        logic             hold_v;
        logic             hold_last;
        logic [CW-1:0]    wcnt;
        logic             done;
        logic             abort;
    } enc_t;

    enc_t q, d;

    phase_e           phase;
    logic             bit_end;
    logic             send_active;
    logic [PW-1:0]    ordered;
    logic [LANES-1:0] cur_bits;
    logic [LANES-1:0] cfg_en;
    logic             ready;
    logic             accept;

    assign send_active = (q.st == ST_SEND);
    assign cfg_en      = q.en;

    led_phase_timer #(
        .TW (TW)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (send_active),
        .t_high_i  (q.th),
        .t_data_i  (q.td),
        .t_low_i   (q.tl),
        .phase_o   (phase),
        .bit_end_o (bit_end)
    );

    led_pix_order #(
        .LANES (LANES)
    ) u_order (
        .code_i (q.ord),
        .rgb_i  (pix_data_i),
        .word_o (ordered)
    );

    led_lane_drive #(
        .LANES (LANES)
    ) u_drive (
        .active_i (send_active),
        .phase_i  (phase),
        .en_i     (q.en),
        .bit_i    (cur_bits),
        .lanes_o  (lanes_o)
    );

    // Current bit of every lane is the top bit of its shift word.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            cur_bits[l] = q.cur[l*PIX_BITS + PIX_BITS - 1];
        end
    end

    always_comb begin
        ready = (q.st == ST_PRIME) || (q.st == ST_STALL) ||
                ((q.st == ST_SEND) && (q.bitn == LAST_BIT) && !q.hold_v && !q.last);
        accept = ready && pix_valid_i;
    end

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.abort = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_PRIME;
                    d.en     = lane_en_i;
                    d.th     = t_high_i;
                    d.td     = t_data_i;
                    d.tl     = t_low_i;
                    d.ord    = order_i;
                    d.hold_v = 1'b0;
                    d.last   = 1'b0;
                end
            end

            ST_PRIME: begin
                if (accept) begin
                    d.st   = ST_SEND;
                    d.cur  = ordered;
                    d.last = pix_last_i;
                    d.bitn = '0;
                end
            end

            ST_SEND: begin
                if (accept) begin
                    d.hold      = ordered;
                    d.hold_v    = 1'b1;
                    d.hold_last = pix_last_i;
                end
                if (bit_end) begin
                    if (q.bitn == LAST_BIT) begin
                        d.bitn = '0;
                        if (q.last) begin
                            d.st   = ST_GAP;
                            d.wcnt = '0;
                        end else if (q.hold_v) begin
                            d.cur    = q.hold;
                            d.last   = q.hold_last;
                            d.hold_v = 1'b0;
                        end else if (accept) begin
                            d.cur    = ordered;
                            d.last   = pix_last_i;
                            d.hold_v = 1'b0;
                        end else begin
                            d.st   = ST_STALL;
                            d.wcnt = '0;
                        end
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        for (int l = 0; l < LANES; l++) begin
                            d.cur[l*PIX_BITS +: PIX_BITS] = {q.cur[l*PIX_BITS +: PIX_BITS-1], 1'b0};
                        end
                    end
                end
            end

            ST_STALL: begin
                if (accept) begin
                    d.st   = ST_SEND;
                    d.cur  = ordered;
                    d.last = pix_last_i;
                    d.bitn = '0;
                end else if (q.wcnt == ABORT_LAST) begin
                    d.st    = ST_GAP;
                    d.wcnt  = '0;
                    d.abort = 1'b1;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end

            ST_GAP: begin
                if (q.wcnt == GAP_LAST) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end

            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pix_ready_o = ready;
    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign aborted_o   = q.abort;

endmodule

module led_par_chk #(
    parameter int LANES = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             aborted_o,
    input logic             pix_ready_o,
    input logic [LANES-1:0] lanes_o,
    input logic [LANES-1:0] cfg_en
);

    AST_IDLE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (lanes_o == '0)); // R1

    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(cfg_en)); // R2

    AST_RISE_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((lanes_o != '0) && ($past(lanes_o) == '0)) |-> (lanes_o == cfg_en)); // R3

    AST_MASKED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((lanes_o & ~cfg_en) == '0)); // R7

    AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_ready_o |-> busy_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R9

    AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aborted_o |-> (busy_o && (lanes_o == '0))); // R11

    AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aborted_o |=> !aborted_o); // R11

endmodule

bind led_par_enc led_par_chk #(
    .LANES (LANES)
) i_led_par_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .aborted_o   (aborted_o),
    .pix_ready_o (pix_ready_o),
    .lanes_o     (lanes_o),
    .cfg_en      (cfg_en)
);

// File: tb/test_led_par_enc.sv
module test_led_par_enc;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int TW         = 12;
    localparam int IDLE_CYC   = 48;
    localparam int MARGIN_CYC = 8;
    localparam int ABORT_LIM  = IDLE_CYC - MARGIN_CYC;
    localparam int PW         = LANES * 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LANES-1:0] lane_en = '0;
    logic [TW-1:0]    t_high = '0, t_data = '0, t_low = '0;
    logic [2:0]       order = '0;
    logic             pix_valid = 1'b0, pix_last = 1'b0;
    logic [PW-1:0]    pix_data = '0;
    logic             pix_ready;
    logic [LANES-1:0] lanes;
    logic             busy, done, aborted;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_par_enc #(
        .LANES(LANES), .TW(TW), .IDLE_CYC(IDLE_CYC), .MARGIN_CYC(MARGIN_CYC)
    ) i_led_par_enc (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lane_en_i(lane_en),
        .t_high_i(t_high), .t_data_i(t_data), .t_low_i(t_low), .order_i(order),
        .pix_valid_i(pix_valid), .pix_last_i(pix_last), .pix_data_i(pix_data),
        .pix_ready_o(pix_ready), .lanes_o(lanes), .busy_o(busy),
        .done_o(done), .aborted_o(aborted)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Decoder state
    int               cyc = 0;
    int               mt1 = 1, mt2 = 1, tsum = 3;
    logic [LANES-1:0] prev = '0;
    int               hi [LANES];
    logic             rx_bits [LANES][128];
    int               rx_n [LANES];
    int               last_rise = 0;
    bit               have_rise = 1'b0;
    int               spacing_bad = 0, shape_bad = 0;
    int               done_cnt = 0, done_cyc = 0;
    int               abort_cnt = 0, abort_cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                if (lanes[l] && !prev[l]) begin
                    hi[l] = 1;
                    if (l == 0) begin
                        if (have_rise && (cyc - last_rise) != tsum) spacing_bad++;
                        last_rise = cyc;
                        have_rise = 1'b1;
                    end
                end else if (lanes[l]) begin
                    hi[l]++;
                end else if (prev[l]) begin
                    if (hi[l] == mt1 || hi[l] == mt1 + mt2) begin
                        if (rx_n[l] < 128) rx_bits[l][rx_n[l]] = (hi[l] != mt1);
                        rx_n[l]++;
                    end else begin
                        shape_bad++;
                    end
                end
            end
            prev = lanes;
            if (done)    begin done_cnt++;  done_cyc = cyc;  end
            if (aborted) begin abort_cnt++; abort_cyc = cyc; end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] lane_rgb(input int seed, input int l);
        return {8'(8'h5A + seed*13 + l*29), 8'(8'hC3 ^ (seed*7 + l)), 8'(l*37 + seed*3 + 1)};
    endfunction

    function automatic logic [PW-1:0] frame(input int seed);
        logic [PW-1:0] f;
        for (int l = 0; l < LANES; l++) f[l*24 +: 24] = lane_rgb(seed, l);
        return f;
    endfunction

    function automatic logic [23:0] exp_word(input logic [23:0] rgb, input int code);
        logic [7:0] r, g, b;
        r = rgb[23:16]; g = rgb[15:8]; b = rgb[7:0];
        case (code)
            1: return {r, g, b};
            2: return {r, b, g};
            3: return {g, b, r};
            4: return {b, r, g};
            5: return {b, g, r};
            default: return {g, r, b};
        endcase
    endfunction

    task automatic clear_rx();
        for (int l = 0; l < LANES; l++) begin rx_n[l] = 0; hi[l] = 0; end
        have_rise = 1'b0; spacing_bad = 0; shape_bad = 0;
        done_cnt = 0; abort_cnt = 0;
    endtask

    task automatic start_frame(input logic [LANES-1:0] en, input int a, input int b,
                               input int c, input int code);
        clear_rx();
        mt1 = a; mt2 = b; tsum = a + b + c;
        @(negedge clk);
        start = 1'b1; lane_en = en; order = 3'(code);
        t_high = TW'(a); t_data = TW'(b); t_low = TW'(c);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push(input logic [PW-1:0] data, input logic last);
        @(negedge clk);
        pix_valid = 1'b1; pix_data = data; pix_last = last;
        while (!pix_ready) @(negedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
        check(done_cnt == 1, "R9", "done pulse count", 96'(done_cnt), 96'd1);
    endtask

    // Compares every lane's decoded stream against npix pixels from seed s0.
    task automatic chk_lanes(input logic [LANES-1:0] mask, input int s0, input int npix,
                             input int code, input string req);
        for (int l = 0; l < LANES; l++) begin
            logic [95:0] exp = '0;
            logic [95:0] act = '0;
            int nb = 24 * npix;
            if (mask[l]) begin
                for (int p = 0; p < npix; p++)
                    exp[95 - 24*p -: 24] = exp_word(lane_rgb(s0 + p, l), code);
                for (int i = 0; i < nb && i < rx_n[l]; i++) act[95 - i] = rx_bits[l][i];
                check(rx_n[l] == nb && act == exp, req, $sformatf("lane %0d stream", l), act, exp);
            end else begin
                check(rx_n[l] == 0, "R7", $sformatf("masked lane %0d bits", l),
                      96'(rx_n[l]), 96'd0);
            end
        end
        check(shape_bad == 0, "R4", "pulse widths", 96'(shape_bad), 96'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lanes == '0 && !busy && !pix_ready && !done && !aborted, "R1", "reset outputs",
              96'({lanes, busy, pix_ready, done, aborted}), 96'd0);
    endtask

    task automatic t_single();
        start_frame(4'b1111, 2, 3, 2, 0);
        check(busy == 1'b1, "R2", "busy after start", 96'(busy), 96'd1);
        push(frame(1), 1'b1);
        wait_done();
        chk_lanes(4'b1111, 1, 1, 0, "R5");
        check(spacing_bad == 0, "R3", "bit period length", 96'(spacing_bad), 96'd0);
        check(done_cyc - last_rise == tsum + IDLE_CYC, "R9", "done timing",
              96'(done_cyc - last_rise), 96'(tsum + IDLE_CYC));
        check(!busy && lanes == '0, "R9", "idle after done", 96'({busy, lanes}), 96'd0);
    endtask

    task automatic t_orders();
        int codes [6] = '{1, 2, 3, 4, 5, 7};
        for (int k = 0; k < 6; k++) begin
            start_frame(4'b1111, 2, 3, 2, codes[k]);
            push(frame(10 + k), 1'b1);
            wait_done();
            chk_lanes(4'b1111, 10 + k, 1, codes[k], "R6");
        end
    endtask

    task automatic t_mask_restart();
        start_frame(4'b0101, 1, 2, 1, 0);
        repeat (2) @(negedge clk);
        start = 1'b1; lane_en = 4'b1111; t_high = TW'(3); t_data = TW'(3); t_low = TW'(3);
        @(negedge clk);
        start = 1'b0;
        push(frame(20), 1'b1);
        wait_done();
        chk_lanes(4'b0101, 20, 1, 0, "R2");
    endtask

    task automatic t_back_to_back();
        start_frame(4'b1111, 2, 3, 2, 1);
        push(frame(30), 1'b0);
        push(frame(31), 1'b0);
        push(frame(32), 1'b1);
        wait_done();
        chk_lanes(4'b1111, 30, 3, 1, "R8");
        check(spacing_bad == 0, "R8", "gap between pixels", 96'(spacing_bad), 96'd0);
    endtask

    task automatic t_stall_resume();
        start_frame(4'b1111, 2, 3, 2, 0);
        push(frame(40), 1'b0);
        repeat (24 * 7 + 10) @(negedge clk);
        check(lanes == '0 && busy, "R10", "lines low while starved", 96'({lanes, busy}), 96'd1);
        push(frame(41), 1'b1);
        wait_done();
        chk_lanes(4'b1111, 40, 2, 0, "R10");
        check(abort_cnt == 0, "R10", "no abort on short stall", 96'(abort_cnt), 96'd0);
        check(spacing_bad == 1, "R10", "single stretched period", 96'(spacing_bad), 96'd1);
    endtask

    task automatic t_abort();
        start_frame(4'b1111, 2, 3, 2, 0);
        push(frame(50), 1'b0);
        wait_done();
        check(abort_cnt == 1, "R11", "abort pulses", 96'(abort_cnt), 96'd1);
        check(abort_cyc - last_rise == tsum + ABORT_LIM, "R11", "abort timing",
              96'(abort_cyc - last_rise), 96'(tsum + ABORT_LIM));
        check(done_cyc - abort_cyc == IDLE_CYC, "R11", "low interval after abort",
              96'(done_cyc - abort_cyc), 96'(IDLE_CYC));
        chk_lanes(4'b1111, 50, 1, 0, "R11");
    endtask

    initial begin
        t_reset();
        t_single();
        t_orders();
        t_mask_restart();
        t_back_to_back();
        t_stall_resume();
        t_abort();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule